// File: doc/BRIEF.md
# Halt-Mode Standby and Wake Controller

This controller puts a processor into a low-power halt state and brings it back. A one-cycle halt strobe, issued while the processor is running, moves the block into the halted state. In that state only the processor clock enable is dropped. The oscillator enable and the peripheral clock enable stay high, so timers, serial ports and other peripherals keep running and can raise the request that ends the halt.

While halted, the block watches two non-maskable request inputs and a set of maskable request lines. The maskable lines are nine external lines plus a parameterised group of internal lines, and each line has its own mask bit and priority level. Any non-maskable request, or any unmasked maskable request, wakes the processor whatever its priority. Waking is kept separate from acknowledging. The block compares the winning request against the priority of the routine already in service, and reports through a one-cycle wake pulse whether the request is acknowledged. It also reports whether the processor should branch to a handler or resume at the instruction after the halt. Any active reset source clears the halted state at once, without waiting for a clock edge.

Top module: `halt_wake_ctrl`

## Requirements
- R1: The halted state is entered on the clock edge that samples `halt_strobe` high while the block is running. A strobe seen while already halted has no effect.
- R2: `cpu_clk_en` is low exactly while `halted` is high. `osc_en` and `periph_clk_en` stay high at all times.
- R3: While the block is running, request inputs have no effect: `wake_pulse` stays low and `halted` stays low.
- R4: While halted, a non-maskable request, or a maskable request whose mask bit is 0, clears `halted` and raises `cpu_clk_en` on the next edge. `wake_pulse` is high for exactly that one cycle. A request whose mask bit is 1 does not wake the block.
- R5: If an unmasked request is already active when the strobe is taken, the block is halted for exactly one cycle and then wakes.
- R6: Among the unmasked maskable requests, the one with the smallest priority value wins, and on a tie the lowest index wins. External line k has index k, internal line k has index 9+k, and the winner is reported on `wake_idx`.
- R7: A winning maskable request is acknowledged (`wake_ack` = 1) when `in_service` is 0, or when its priority value is strictly smaller than `svc_prio`. Otherwise it wakes the block without an acknowledge.
- R8: A wake by `nmi_req` or `wdt_nmi_req` always gives `wake_nmi` = 1, `wake_ack` = 1 and `wake_branch` = 1, whatever `int_enable` is. It takes precedence over maskable requests, with `wake_idx` = 0.
- R9: For a maskable wake, `wake_branch` is high only when `int_enable` is 1 and the request is acknowledged. Otherwise `wake_branch` = 0, which means resume at the next instruction.
- R10: `rst_n` low, or any bit of `rst_src` high, clears `halted` asynchronously, holds `cpu_clk_en` high and produces no wake pulse.
- R11: `wake_branch`, `wake_ack`, `wake_nmi` and `wake_idx` are zero in every cycle where `wake_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_src | input | 4 | Reset sources: pin, watchdog, low voltage, clock monitor; any bit high resets |
| halt_strobe | input | 1 | One-cycle request to enter halt |
| nmi_req | input | 1 | Non-maskable request from the pin |
| wdt_nmi_req | input | 1 | Non-maskable request from the watchdog |
| ext_req | input | 9 | External maskable request lines |
| ext_mask | input | 9 | External mask bits, 1 = masked |
| ext_prio | input | 27 | External priority levels, 3 bits per line, line k at bits 3k+2:3k |
| int_req | input | 8 | Internal peripheral request lines |
| int_mask | input | 8 | Internal mask bits, 1 = masked |
| int_prio | input | 24 | Internal priority levels, 3 bits per line |
| in_service | input | 1 | A maskable routine is in service |
| svc_prio | input | 3 | Priority value of the routine in service |
| int_enable | input | 1 | Processor interrupt-enable flag |
| halted | output | 1 | Block is in the halted state |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_branch | output | 1 | 1 = branch to handler, 0 = resume at next instruction |
| wake_ack | output | 1 | Waking request is acknowledged |
| wake_nmi | output | 1 | Wake was caused by a non-maskable request |
| wake_idx | output | 5 | Index of the acknowledged or waking maskable line |

## Verification
Several rules are checked by assertions on every cycle. Entry into halt follows the strobe. No pulse appears unless the block was halted. A wake always follows a qualifying request on the next edge, and the pulse lasts one cycle. A branch never appears without an acknowledge, and a non-maskable wake always branches. Other behaviour can only be shown by the bench's directed scenarios:
- the priority comparison against the routine in service;
- the tie-break between lines and the index numbering;
- the resume choice when interrupts are disabled;
- the effect of masked lines;
- the asynchronous clear by a reset source in the middle of a cycle.

// File: rtl/halt_wake_ctrl.sv
`timescale 1ns/1ps
module halt_wake_ctrl #(
  parameter int N_EXT  = 9,
  parameter int N_INT  = 8,
  parameter int PRIO_W = 3,
  parameter int N_RST  = 4,
  localparam int N_ALL = N_EXT + N_INT,
  localparam int IDX_W = $clog2(N_ALL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_RST-1:0]        rst_src,
  input  logic                    halt_strobe,
  input  logic                    nmi_req,
  input  logic                    wdt_nmi_req,
  input  logic [N_EXT-1:0]        ext_req,
  input  logic [N_EXT-1:0]        ext_mask,
  input  logic [N_EXT*PRIO_W-1:0] ext_prio,
  input  logic [N_INT-1:0]        int_req,
  input  logic [N_INT-1:0]        int_mask,
  input  logic [N_INT*PRIO_W-1:0] int_prio,
  input  logic                    in_service,
  input  logic [PRIO_W-1:0]       svc_prio,
  input  logic                    int_enable,
  output logic                    halted,
  output logic                    cpu_clk_en,
  output logic                    osc_en,
  output logic                    periph_clk_en,
  output logic                    wake_pulse,
  output logic                    wake_branch,
  output logic                    wake_ack,
  output logic                    wake_nmi,
  output logic [IDX_W-1:0]        wake_idx
);

  logic              arst_n;
  logic              nmi_any;
  logic [N_ALL-1:0]  req_v;
  logic [PRIO_W-1:0] prio_a [N_ALL];
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;
  logic              mask_ack;

  assign arst_n        = rst_n & ~(|rst_src);
  assign nmi_any       = nmi_req | wdt_nmi_req;
  assign req_v         = {int_req & ~int_mask, ext_req & ~ext_mask};
  assign cpu_clk_en    = ~halted;
  assign osc_en        = 1'b1;
  assign periph_clk_en = 1'b1;

  for (genvar g = 0; g < N_ALL; g++) begin : g_prio
    if (g < N_EXT) begin : g_ext
      assign prio_a[g] = ext_prio[g*PRIO_W +: PRIO_W];
    end else begin : g_int
      assign prio_a[g] = int_prio[(g-N_EXT)*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < N_ALL; i++) begin
      if (req_v[i] && (!found || prio_a[i] < best_p)) begin
        found  = 1'b1;
        best_p = prio_a[i];
        best_i = IDX_W'(i);
      end
    end
  end

  assign mask_ack = !in_service || (best_p < svc_prio);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      halted      <= 1'b0;
      wake_pulse  <= 1'b0;
      wake_branch <= 1'b0;
      wake_ack    <= 1'b0;
      wake_nmi    <= 1'b0;
      wake_idx    <= '0;
    end else begin
      wake_pulse  <= 1'b0;
      wake_branch <= 1'b0;
      wake_ack    <= 1'b0;
      wake_nmi    <= 1'b0;
      wake_idx    <= '0;
      if (!halted) begin
        if (halt_strobe) halted <= 1'b1;
      end else if (nmi_any) begin
        halted      <= 1'b0;
        wake_pulse  <= 1'b1;
        wake_branch <= 1'b1;
        wake_ack    <= 1'b1;
        wake_nmi    <= 1'b1;
      end else if (found) begin
        halted      <= 1'b0;
        wake_pulse  <= 1'b1;
        wake_ack    <= mask_ack;
        wake_branch <= mask_ack & int_enable;
        wake_idx    <= best_i;
      end
    end
  end

  AST_ENTER_ON_STROBE: assert property (@(posedge clk) disable iff (!arst_n)
    (!halted && halt_strobe) |=> halted); // R1
  AST_NO_PULSE_RUNNING: assert property (@(posedge clk) disable iff (!arst_n)
    !halted |=> !wake_pulse); // R3
  AST_WAKE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!arst_n)
    (halted && (nmi_any || found)) |=> (wake_pulse && cpu_clk_en)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    wake_pulse |=> !wake_pulse); // R4
  AST_NMI_BRANCHES: assert property (@(posedge clk) disable iff (!arst_n)
    (wake_pulse && wake_nmi) |-> (wake_branch && wake_ack)); // R8
  AST_BRANCH_NEEDS_ACK: assert property (@(posedge clk) disable iff (!arst_n)
    wake_branch |-> wake_ack); // R9
  AST_QUIET_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    !wake_pulse |-> !(wake_branch || wake_ack || wake_nmi || (wake_idx != '0))); // R11

endmodule

// File: tb/halt_wake_ctrl_tb.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] rst_src = 0;
  logic halt_strobe = 0, nmi_req = 0, wdt_nmi_req = 0;
  logic [8:0] ext_req = 0, ext_mask = 0;
  logic [26:0] ext_prio = '1;
  logic [7:0] int_req = 0, int_mask = 0;
  logic [23:0] int_prio = '1;
  logic in_service = 0;
  logic [2:0] svc_prio = 0;
  logic int_enable = 1;
  logic halted, cpu_clk_en, osc_en, periph_clk_en;
  logic wake_pulse, wake_branch, wake_ack, wake_nmi;
  logic [4:0] wake_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  halt_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .halt_strobe(halt_strobe),
    .nmi_req(nmi_req), .wdt_nmi_req(wdt_nmi_req), .ext_req(ext_req),
    .ext_mask(ext_mask), .ext_prio(ext_prio), .int_req(int_req),
    .int_mask(int_mask), .int_prio(int_prio), .in_service(in_service),
    .svc_prio(svc_prio), .int_enable(int_enable), .halted(halted),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
    .wake_pulse(wake_pulse), .wake_branch(wake_branch), .wake_ack(wake_ack),
    .wake_nmi(wake_nmi), .wake_idx(wake_idx));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    nmi_req = 0; wdt_nmi_req = 0; ext_req = 0; int_req = 0;
  endtask

  task automatic enter_halt();
    halt_strobe = 1;
    @(negedge clk);
    halt_strobe = 0;
    chk("R1 halted after strobe", halted, 1);
    chk("R2 cpu clock off", cpu_clk_en, 0);
    chk("R2 osc and periph on", {osc_en, periph_clk_en}, 2'b11);
  endtask

  task automatic expect_wake(string req, bit br, bit ack, bit nmi, int idx);
    @(negedge clk);
    clear_reqs();
    chk({req, " pulse"}, wake_pulse, 1);
    chk({req, " R4 running"}, {halted, cpu_clk_en}, 2'b01);
    chk({req, " branch"}, wake_branch, br);
    chk({req, " ack"}, wake_ack, ack);
    chk({req, " nmi"}, wake_nmi, nmi);
    chk({req, " idx"}, wake_idx, idx);
    @(negedge clk);
    chk("R4 R11 pulse single", {wake_pulse, wake_branch, wake_ack, wake_nmi, wake_idx}, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset halted", halted, 0);
    chk("R2 reset clocks", {cpu_clk_en, osc_en, periph_clk_en}, 3'b111);
    chk("R11 reset outputs", {wake_pulse, wake_branch, wake_ack, wake_nmi, wake_idx}, 0);
  endtask

  task automatic t_running_ignores();
    ext_req = 9'h1F; nmi_req = 1;
    repeat (2) @(negedge clk);
    chk("R3 no pulse while running", {wake_pulse, halted}, 0);
    clear_reqs();
  endtask

  task automatic t_strobe_while_halted();
    enter_halt();
    halt_strobe = 1;
    @(negedge clk);
    halt_strobe = 0;
    chk("R1 strobe while halted", {halted, wake_pulse}, 2'b10);
    ext_req[2] = 1; ext_prio[8:6] = 3'd4;
    expect_wake("R7 no service ack R9 branch", 1, 1, 0, 2);
  endtask

  task automatic t_masked();
    enter_halt();
    ext_mask[5] = 1; ext_req[5] = 1; int_mask[0] = 1; int_req[0] = 1;
    repeat (2) @(negedge clk);
    chk("R4 masked lines do not wake", {halted, wake_pulse}, 2'b10);
    clear_reqs(); ext_mask = 0; int_mask = 0;
    int_req[3] = 1; int_prio[11:9] = 3'd2;
    expect_wake("R6 internal index", 1, 1, 0, 12);
  endtask

  task automatic t_di_resume();
    int_enable = 0;
    enter_halt();
    ext_req[0] = 1;
    expect_wake("R9 disabled resumes", 0, 1, 0, 0);
    int_enable = 1;
  endtask

  task automatic t_low_prio_in_service();
    in_service = 1; svc_prio = 3'd3;
    enter_halt();
    ext_req[4] = 1; ext_prio[14:12] = 3'd5;
    expect_wake("R7 lower priority not acked", 0, 0, 0, 4);
    enter_halt();
    ext_req[4] = 1; ext_prio[14:12] = 3'd3;
    expect_wake("R7 equal priority not acked", 0, 0, 0, 4);
  endtask

  task automatic t_high_prio_in_service();
    in_service = 1; svc_prio = 3'd3;
    enter_halt();
    ext_req[6] = 1; ext_prio[20:18] = 3'd1;
    expect_wake("R7 higher priority acked", 1, 1, 0, 6);
    in_service = 0;
  endtask

  task automatic t_select();
    enter_halt();
    ext_prio = '1; int_prio = '1;
    ext_req[1] = 1; ext_prio[5:3] = 3'd2;
    ext_req[7] = 1; ext_prio[23:21] = 3'd2;
    int_req[1] = 1; int_prio[5:3] = 3'd6;
    expect_wake("R6 tie lowest index", 1, 1, 0, 1);
    enter_halt();
    ext_req[1] = 1; int_req[5] = 1; int_prio[17:15] = 3'd0;
    expect_wake("R6 smallest value wins", 1, 1, 0, 14);
  endtask

  task automatic t_nmi();
    int_enable = 0; in_service = 1; svc_prio = 3'd0;
    enter_halt();
    nmi_req = 1; ext_req[3] = 1;
    expect_wake("R8 pin nmi", 1, 1, 1, 0);
    enter_halt();
    wdt_nmi_req = 1;
    expect_wake("R8 watchdog nmi", 1, 1, 1, 0);
    int_enable = 1; in_service = 0;
  endtask

  task automatic t_pending();
    ext_req[8] = 1;
    halt_strobe = 1;
    @(negedge clk);
    halt_strobe = 0;
    chk("R5 halted one cycle", halted, 1);
    expect_wake("R5 pending wakes", 1, 1, 0, 8);
  endtask

  task automatic t_reset_wake();
    enter_halt();
    #1 rst_src = 4'b0100;
    #0.5;
    chk("R10 async clear", {halted, cpu_clk_en}, 2'b01);
    @(negedge clk);
    rst_src = 0;
    chk("R10 no pulse", wake_pulse, 0);
    enter_halt();
    #1 rst_n = 0;
    #0.5;
    chk("R10 rst_n clear", halted, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 stays running", {halted, wake_pulse}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_running_ignores();
    t_strobe_while_halted();
    t_masked();
    t_di_resume();
    t_low_prio_in_service();
    t_high_prio_in_service();
    t_select();
    t_nmi();
    t_pending();
    t_reset_wake();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule